// File: doc/BRIEF.md
# Nested Interrupt Processor Port

This block is the per-processor side of an interrupt controller. Every cycle it looks at all interrupts that are both pending and enabled, picks the most urgent one, qualifies it against a programmable priority mask and against the priority of the interrupt the processor is currently servicing, and drives a single request line to the processor. The pending, enable, priority, trigger and routing state of each interrupt comes in on per-interrupt input vectors from a separate distributor; this block hands back one-cycle pulses that tell the distributor which pending bits to clear or set.

Software talks to the block through a small register port. Reading the acknowledge register claims the selected interrupt, and writing an interrupt ID to the end-of-interrupt register retires it. Claimed interrupts may preempt each other: each claimed ID remembers which ID was running when it was claimed, forming a linked chain of preempted interrupts. Retiring the running ID resumes the one it preempted; retiring an ID deeper in the chain removes it from the chain without disturbing the running one. The ID value 1023 means "no interrupt", and the idle running priority is 0x100, less urgent than any 8-bit priority.

Top module: `nest_irq_cpu_if`

## Requirements
- R1: After reset the control enable reads 0, the priority mask reads 0xF0, the running priority reads 0x100, the highest-pending register reads 1023 and the request line is low.
- R2: Among interrupts whose pending and enable inputs are both 1, the one with the numerically lowest priority is selected; on equal priority the lowest ID wins.
- R3: One clock after the inputs settle, the highest-pending register (offset 0x18, ID in bits 9:0) holds the selected ID when its priority is less than or equal to the priority mask, and 1023 otherwise.
- R4: The request line is high exactly when the highest-pending register holds an ID whose priority is strictly lower in value than the running priority.
- R5: While the global enable input is low or control bit 0 is 0, the request line is low and the highest-pending register reads 1023.
- R6: A read of the acknowledge register (offset 0x0C) returns 1023 and changes nothing when no ID is pending or the pending priority is not strictly below the running priority.
- R7: A successful acknowledge returns the pending ID in the same cycle, pulses the one-hot clear output at that ID's bit, drives the clear-all output to that interrupt's one-of-N model input, and makes that ID and its priority the running ones.
- R8: An end-of-interrupt write (offset 0x10, ID in bits 9:0) naming the running ID restores the ID that it preempted as running, with that ID's priority, or 0x100 when it preempted nothing.
- R9: An end-of-interrupt write naming an ID that is in the preemption chain but not running removes it from the chain and leaves the running ID and priority unchanged.
- R10: An end-of-interrupt write while nothing is running has no effect: no set pulse and no state change.
- R11: An end-of-interrupt write while something is running pulses the one-hot set output at the named ID when that interrupt is level-sensitive (trigger input 0), enabled, its level input is high and it targets this processor.
- R12: Offset 0x00 bit 0 is the processor enable and offset 0x04 bits 7:0 the priority mask, both read/write; offset 0x14 reads the running priority; writes to read-only offsets are ignored and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global enable from the distributor |
| irq_pend | input | NUM_IRQ | Pending bit per interrupt for this processor |
| irq_en | input | NUM_IRQ | Enable bit per interrupt |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority per interrupt, ID i at bits i*PRIO_W upward |
| irq_level | input | NUM_IRQ | Current level of each interrupt line |
| irq_edge | input | NUM_IRQ | 1 = edge triggered, 0 = level sensitive |
| irq_model | input | NUM_IRQ | 1 = one-of-N model (claim clears all processors) |
| irq_tgt | input | NUM_IRQ | 1 = interrupt targets this processor |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational during reg_rd |
| irq_req | output | 1 | Interrupt request to the processor |
| clr_pend_o | output | NUM_IRQ | One-hot pulse: clear pending of the claimed ID |
| clr_all_o | output | 1 | Qualifies clr_pend_o: clear for every processor |
| set_pend_o | output | NUM_IRQ | One-hot pulse: re-pend a still-asserted level interrupt |

## Verification
The assertions assume that read and write strobes are never raised together, that the distributor holds the priority of a running interrupt steady while it runs, and that end-of-interrupt IDs name interrupts that were claimed. The stimulus keeps to this by issuing one register access at a time, fixing priorities before each nesting sequence, and retiring only IDs it claimed earlier, except in the deliberate case where nothing is running. Random sweeps keep the running priority idle so that the expected selection depends only on the pending, enable and priority inputs and the mask.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
   localparam int ID_W = 10;
   localparam int RA_W = 5;
   localparam logic [ID_W-1:0] NO_IRQ = '1;

   typedef enum logic [RA_W-1:0] {
      RA_CTRL  = 5'h00,
      RA_PMASK = 5'h04,
      RA_ACK   = 5'h0C,
      RA_EOI   = 5'h10,
      RA_RPRIO = 5'h14,
      RA_HPEND = 5'h18
   } reg_ofs_e;
endpackage

// File: rtl/nest_irq_scan.sv
module nest_irq_scan #(
   parameter int NUM_IRQ   = 16,
   parameter int PRIO_W    = 8,
   parameter int ID_W      = 10,
   parameter bit SCAN_TREE = 1'b0
) (
   input  logic [NUM_IRQ-1:0]        cand_vld,
   input  logic [NUM_IRQ*PRIO_W-1:0] cand_prio,
   output logic [ID_W-1:0]           best_id,
   output logic [PRIO_W:0]           best_prio
);
   localparam int LV = $clog2(NUM_IRQ);
   localparam int NP = 1 << LV;
   localparam logic [PRIO_W:0] IDLE_P = {1'b1, {PRIO_W{1'b0}}};
   localparam logic [ID_W-1:0] NONE   = '1;

   logic [PRIO_W:0] leaf_p [NP];
   logic [ID_W-1:0] leaf_i [NP];

   for (genvar g = 0; g < NP; g++) begin : g_leaf
      if (g < NUM_IRQ) begin : g_real
         assign leaf_p[g] = cand_vld[g] ? {1'b0, cand_prio[g*PRIO_W +: PRIO_W]} : IDLE_P;
         assign leaf_i[g] = ID_W'(g);
      end else begin : g_pad
         assign leaf_p[g] = IDLE_P;
         assign leaf_i[g] = NONE;
      end
   end

   if (SCAN_TREE) begin : g_tree
      // Binary tournament; the left (lower-ID) side keeps ties.
      always_comb begin
         logic [PRIO_W:0] tp [2*NP];
         logic [ID_W-1:0] ti [2*NP];
         tp[0] = IDLE_P;
         ti[0] = NONE;
         for (int i = 0; i < NP; i++) begin
            tp[NP+i] = leaf_p[i];
            ti[NP+i] = leaf_i[i];
         end
         for (int k = NP-1; k >= 1; k--) begin
            if (tp[2*k+1] < tp[2*k]) begin
               tp[k] = tp[2*k+1];
               ti[k] = ti[2*k+1];
            end else begin
               tp[k] = tp[2*k];
               ti[k] = ti[2*k];
            end
         end
         best_prio = tp[1];
         best_id   = (tp[1] == IDLE_P) ? NONE : ti[1];
      end
   end else begin : g_line
      // Ascending scan; only a strictly better value replaces the candidate.
      always_comb begin
         best_prio = IDLE_P;
         best_id   = NONE;
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (leaf_p[i] < best_prio) begin
               best_prio = leaf_p[i];
               best_id   = leaf_i[i];
            end
         end
      end
   end
endmodule

// File: rtl/nest_irq_chain.sv
module nest_irq_chain #(
   parameter int NUM_IRQ = 16,
   parameter int ID_W    = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [ID_W-1:0] push_at,
   input  logic [ID_W-1:0] push_val,
   input  logic            cut,
   input  logic [ID_W-1:0] cut_id,
   input  logic [ID_W-1:0] head_id,
   output logic [ID_W-1:0] head_link
);
   localparam int IDX_W = $clog2(NUM_IRQ);
   localparam logic [ID_W-1:0] NONE = '1;

   logic [ID_W-1:0] link_q [NUM_IRQ];
   logic            found;
   logic [ID_W-1:0] fix_at;
   logic [ID_W-1:0] cut_next;

   function automatic logic [ID_W-1:0] peek(input logic [ID_W-1:0] id);
      if (id < ID_W'(NUM_IRQ)) return link_q[id[IDX_W-1:0]];
      return NONE;
   endfunction

   assign head_link = peek(head_id);
   assign cut_next  = peek(cut_id);

   // Follow the chain from the running ID until the predecessor of cut_id
   // or the terminator is met; at most NUM_IRQ hops.
   always_comb begin
      logic [ID_W-1:0] cur;
      logic [ID_W-1:0] nxt;
      logic            stop;
      cur    = head_id;
      nxt    = NONE;
      stop   = (head_id == NONE);
      found  = 1'b0;
      fix_at = NONE;
      for (int k = 0; k < NUM_IRQ; k++) begin
         if (!stop) begin
            nxt = peek(cur);
            if (nxt == NONE) begin
               stop = 1'b1;
            end else if (nxt == cut_id) begin
               found  = 1'b1;
               fix_at = cur;
               stop   = 1'b1;
            end else begin
               cur = nxt;
            end
         end
      end
   end

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_link
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            link_q[g] <= NONE;
         end else if (push && push_at == ID_W'(g)) begin
            link_q[g] <= push_val;
         end else if (cut && found && fix_at == ID_W'(g)) begin
            link_q[g] <= cut_next;
         end
      end
   end
endmodule

// File: rtl/nest_irq_cpu_if.sv
module nest_irq_cpu_if
   import nest_irq_pkg::*;
#(
   parameter int NUM_IRQ   = 16,
   parameter int PRIO_W    = 8,
   parameter bit SCAN_TREE = 1'b0,
   parameter logic [PRIO_W-1:0] PMASK_RST = 'hF0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dist_en,
   input  logic [NUM_IRQ-1:0]        irq_pend,
   input  logic [NUM_IRQ-1:0]        irq_en,
   input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
   input  logic [NUM_IRQ-1:0]        irq_level,
   input  logic [NUM_IRQ-1:0]        irq_edge,
   input  logic [NUM_IRQ-1:0]        irq_model,
   input  logic [NUM_IRQ-1:0]        irq_tgt,
   input  logic                      reg_rd,
   input  logic                      reg_wr,
   input  logic [RA_W-1:0]           reg_addr,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   output logic                      irq_req,
   output logic [NUM_IRQ-1:0]        clr_pend_o,
   output logic                      clr_all_o,
   output logic [NUM_IRQ-1:0]        set_pend_o
);
   localparam int IDX_W = $clog2(NUM_IRQ);
   localparam logic [PRIO_W:0] IDLE_P = {1'b1, {PRIO_W{1'b0}}};

   if (NUM_IRQ < 2 || NUM_IRQ >= 1020) begin : g_bad_num
      $error("NUM_IRQ must lie in 2..1019");
   end
   if (PRIO_W < 1 || PRIO_W > 30) begin : g_bad_prio
      $error("PRIO_W must lie in 1..30");
   end

   logic              cpu_en_q;
   logic [PRIO_W-1:0] pmask_q;
   logic [ID_W-1:0]   hp_id;
   logic [PRIO_W:0]   hp_prio;
   logic [ID_W-1:0]   run_id;
   logic [PRIO_W:0]   run_prio;

   logic [ID_W-1:0]   best_id;
   logic [PRIO_W:0]   best_prio;
   logic [PRIO_W-1:0] prio_arr [NUM_IRQ];
   logic [ID_W-1:0]   head_link;

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
      assign prio_arr[g] = irq_prio[g*PRIO_W +: PRIO_W];
   end

   nest_irq_scan #(
      .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W), .SCAN_TREE(SCAN_TREE)
   ) u_scan (
      .cand_vld (irq_pend & irq_en),
      .cand_prio(irq_prio),
      .best_id  (best_id),
      .best_prio(best_prio)
   );

   // Qualified, registered scan result.
   logic gate_on;
   logic hp_ok;
   assign gate_on = dist_en && cpu_en_q;
   assign hp_ok   = gate_on && (best_prio <= {1'b0, pmask_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hp_id   <= NO_IRQ;
         hp_prio <= IDLE_P;
      end else begin
         hp_id   <= hp_ok ? best_id : NO_IRQ;
         hp_prio <= hp_ok ? best_prio : IDLE_P;
      end
   end

   assign irq_req = (hp_id != NO_IRQ) && (hp_prio < run_prio);

   // Acknowledge
   logic            ack_rd, ack_ok, ack_fire;
   logic [ID_W-1:0] ack_val;
   logic [IDX_W-1:0] hp_idx;
   assign ack_rd   = reg_rd && (reg_addr == RA_ACK);
   assign ack_ok   = (hp_id != NO_IRQ) && (hp_prio < run_prio);
   assign ack_val  = ack_ok ? hp_id : NO_IRQ;
   assign ack_fire = ack_rd && ack_ok;
   assign hp_idx   = hp_id[IDX_W-1:0];

   assign clr_pend_o = ack_fire ? (NUM_IRQ'(1) << hp_idx) : '0;
   assign clr_all_o  = ack_fire && irq_model[hp_idx];

   // End of interrupt
   logic             eoi_wr, eoi_live, eoi_pop, eoi_cut, eoi_in_rng, repend;
   logic [ID_W-1:0]  eoi_id;
   logic [IDX_W-1:0] eoi_idx;
   assign eoi_wr     = reg_wr && !reg_rd && (reg_addr == RA_EOI);
   assign eoi_id     = reg_wdata[ID_W-1:0];
   assign eoi_idx    = eoi_id[IDX_W-1:0];
   assign eoi_live   = eoi_wr && (run_id != NO_IRQ);
   assign eoi_pop    = eoi_live && (eoi_id == run_id);
   assign eoi_cut    = eoi_live && (eoi_id != run_id);
   assign eoi_in_rng = eoi_id < ID_W'(NUM_IRQ);
   assign repend     = eoi_live && eoi_in_rng && !irq_edge[eoi_idx] && irq_en[eoi_idx]
                       && irq_level[eoi_idx] && irq_tgt[eoi_idx];
   assign set_pend_o = repend ? (NUM_IRQ'(1) << eoi_idx) : '0;

   nest_irq_chain #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack_fire),
      .push_at  (hp_id),
      .push_val (run_id),
      .cut      (eoi_cut),
      .cut_id   (eoi_id),
      .head_id  (run_id),
      .head_link(head_link)
   );

   // Running state and control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_id   <= NO_IRQ;
         run_prio <= IDLE_P;
         cpu_en_q <= 1'b0;
         pmask_q  <= PMASK_RST;
      end else begin
         if (ack_fire) begin
            run_id   <= hp_id;
            run_prio <= hp_prio;
         end else if (eoi_pop) begin
            run_id   <= head_link;
            run_prio <= (head_link == NO_IRQ) ? IDLE_P
                        : {1'b0, prio_arr[head_link[IDX_W-1:0]]};
         end
         if (reg_wr && !reg_rd) begin
            if (reg_addr == RA_CTRL)  cpu_en_q <= reg_wdata[0];
            if (reg_addr == RA_PMASK) pmask_q  <= reg_wdata[PRIO_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         case (reg_addr)
            RA_CTRL:  reg_rdata[0]          = cpu_en_q;
            RA_PMASK: reg_rdata[PRIO_W-1:0] = pmask_q;
            RA_ACK:   reg_rdata[ID_W-1:0]   = ack_val;
            RA_RPRIO: reg_rdata[PRIO_W:0]   = run_prio;
            RA_HPEND: reg_rdata[ID_W-1:0]   = hp_id;
            default:  reg_rdata             = '0;
         endcase
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[31:ID_W];
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
   parameter int PRIO_W = 8,
   parameter int ID_W   = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dist_en,
   input logic            cpu_en_q,
   input logic            irq_req,
   input logic            ack_fire,
   input logic            eoi_wr,
   input logic [ID_W-1:0] eoi_id,
   input logic [ID_W-1:0] hp_id,
   input logic [ID_W-1:0] run_id,
   input logic [PRIO_W:0] run_prio,
   input logic [ID_W-1:0] head_link,
   input logic [15:0]     set_any
);
   localparam logic [ID_W-1:0] NONE = '1;

   // R5: a disabled global or processor enable silences the request line
   a_r5_glob_off: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dist_en) |-> !irq_req);
   a_r5_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cpu_en_q) |-> !irq_req);
   // R6: a claim always moves to a strictly more urgent running priority
   a_r6_preempt_only: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> (run_prio < $past(run_prio)));
   // R7: a claim makes the pending ID the running one
   a_r7_claim_runs: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> (run_id == $past(hp_id)));
   // R8: retiring the running ID resumes its predecessor
   a_r8_pop_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && run_id != NONE && eoi_id == run_id) |=> (run_id == $past(head_link)));
   // R9: retiring a non-running ID leaves the running state alone
   a_r9_cut_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && run_id != NONE && eoi_id != run_id) |=> ($stable(run_id) && $stable(run_prio)));
   // R10: retiring while idle does nothing
   a_r10_idle_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && run_id == NONE) |-> (set_any == '0));
   a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && run_id == NONE) |=> (run_id == NONE));
endmodule

bind nest_irq_cpu_if nest_irq_chk #(.PRIO_W(PRIO_W), .ID_W(nest_irq_pkg::ID_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dist_en  (dist_en),
   .cpu_en_q (cpu_en_q),
   .irq_req  (irq_req),
   .ack_fire (ack_fire),
   .eoi_wr   (eoi_wr),
   .eoi_id   (eoi_id),
   .hp_id    (hp_id),
   .run_id   (run_id),
   .run_prio (run_prio),
   .head_link(head_link),
   .set_any  (16'(set_pend_o))
);

// File: tb/sim_nest_irq_cpu_if.sv
module sim_nest_irq_cpu_if;
   localparam int CLK_P = 10;
   localparam int N     = 8;
   localparam int PW    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dist_en = 1'b1;
   logic [N-1:0] pend = '0, en = '0, lvl = '0, edg = '0, mdl = '0, tgt = '0;
   logic [PW-1:0] pr [N];
   logic [N*PW-1:0] pr_flat;
   logic reg_rd = 1'b0, reg_wr = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic irq_req, clr_all_o;
   logic [N-1:0] clr_pend_o, set_pend_o;

   int nchk = 0, nerr = 0;
   bit done = 1'b0;
   logic [31:0] seed = 32'h1234_5679;

   always #(CLK_P/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) pr_flat[i*PW +: PW] = pr[i];
   end

   nest_irq_cpu_if #(.NUM_IRQ(N), .PRIO_W(PW), .SCAN_TREE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .irq_pend(pend), .irq_en(en),
      .irq_prio(pr_flat), .irq_level(lvl), .irq_edge(edg), .irq_model(mdl), .irq_tgt(tgt),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_req(irq_req), .clr_pend_o(clr_pend_o),
      .clr_all_o(clr_all_o), .set_pend_o(set_pend_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output int v);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = int'(reg_rdata);
      reg_rd = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input int d, output int sp);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      #1 sp = int'(set_pend_o);
      @(negedge clk);
      reg_wr = 1'b0;
      settle();
   endtask

   task automatic ack(output int id, output int clr, output int all);
      @(negedge clk);
      reg_addr = 5'h0C; reg_rd = 1'b1;
      #1 id = int'(reg_rdata); clr = int'(clr_pend_o); all = int'(clr_all_o);
      @(negedge clk);
      reg_rd = 1'b0;
      pend = pend & ~clr_pend_o;
      pend = pend & ~N'(clr);
      settle();
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x;
      x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      return x;
   endfunction

   initial begin
      #(CLK_P*200000);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int v, sp, id, clr, all, eid, epr, mask;
      for (int i = 0; i < N; i++) pr[i] = 8'hF0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(5'h00, v); chk("R1 ctrl", v, 0);
      rd(5'h04, v); chk("R1 mask", v, 'hF0);
      rd(5'h14, v); chk("R1 rprio", v, 'h100);
      rd(5'h18, v); chk("R1 hpend", v, 1023);
      chk("R1 req", int'(irq_req), 0);

      // R12 register map
      wr(5'h00, 1, sp);
      rd(5'h00, v); chk("R12 ctrl", v, 1);
      wr(5'h04, 'h1AB, sp);
      rd(5'h04, v); chk("R12 mask 8 bits", v, 'hAB);
      wr(5'h04, 'hFF, sp);
      rd(5'h08, v); chk("R12 unmapped", v, 0);
      wr(5'h14, 5, sp);
      rd(5'h14, v); chk("R12 rprio ro", v, 'h100);

      // R5 enables
      en = '1; pr[3] = 8'h10; pend = 8'h08; settle();
      rd(5'h18, v); chk("R3 hp id3", v, 3);
      chk("R4 req", int'(irq_req), 1);
      dist_en = 1'b0; settle();
      chk("R5 glob req", int'(irq_req), 0);
      rd(5'h18, v); chk("R5 glob hp", v, 1023);
      dist_en = 1'b1; wr(5'h00, 0, sp);
      chk("R5 cpu req", int'(irq_req), 0);
      rd(5'h18, v); chk("R5 cpu hp", v, 1023);
      wr(5'h00, 1, sp);

      // R2 R3 R4 sweep, running idle
      for (int t = 0; t < 160; t++) begin
         seed = nxt(seed); pend = seed[7:0];
         seed = nxt(seed); en = seed[7:0] | seed[15:8];
         seed = nxt(seed);
         for (int i = 0; i < N; i++)
            pr[i] = (seed[2*i +: 2] == 2'd3) ? 8'hF0 : 8'(seed[2*i +: 2] * 8'h40);
         case (t % 5)
            0: mask = 'hFF; 1: mask = 'hF0; 2: mask = 'h80; 3: mask = 'h40; default: mask = 0;
         endcase
         wr(5'h04, mask, sp);
         eid = 1023; epr = 256;
         for (int i = 0; i < N; i++)
            if (pend[i] && en[i] && int'(pr[i]) < epr) begin epr = int'(pr[i]); eid = i; end
         if (epr > mask) eid = 1023;
         rd(5'h18, v); chk("R2 R3 sweep hp", v, eid);
         chk("R4 sweep req", int'(irq_req), (eid != 1023) ? 1 : 0);
      end

      // Nesting scenario
      wr(5'h04, 'hFF, sp);
      pend = '0; en = '1; mdl = '0; lvl = '0; edg = '0; tgt = '1;
      for (int i = 0; i < N; i++) pr[i] = 8'hF0;
      pr[2] = 8'h80; pr[3] = 8'h80; pr[5] = 8'h40; pr[6] = 8'h20; pr[4] = 8'h30;
      pend[2] = 1'b1; settle();
      chk("R4 req id2", int'(irq_req), 1);
      ack(id, clr, all);
      chk("R7 ack id", id, 2); chk("R7 clr bit", clr, 'h04); chk("R7 clr_all", all, 0);
      rd(5'h14, v); chk("R7 rprio", v, 'h80);
      chk("R4 req after claim", int'(irq_req), 0);
      pend[3] = 1'b1; settle();
      chk("R4 equal prio no req", int'(irq_req), 0);
      rd(5'h18, v); chk("R3 equal prio hp", v, 3);
      ack(id, clr, all);
      chk("R6 equal prio ack", id, 1023); chk("R6 no clr", clr, 0);
      rd(5'h14, v); chk("R6 rprio kept", v, 'h80);
      pend[3] = 1'b0; mdl[5] = 1'b1; pend[5] = 1'b1; settle();
      ack(id, clr, all);
      chk("R7 nest id5", id, 5); chk("R7 clr bit5", clr, 'h20); chk("R7 clr_all model", all, 1);
      pend[6] = 1'b1; settle();
      ack(id, clr, all);
      chk("R7 nest id6", id, 6);
      rd(5'h14, v); chk("R7 rprio 20", v, 'h20);
      wr(5'h10, 5, sp);
      rd(5'h14, v); chk("R9 mid unlink", v, 'h20);
      wr(5'h10, 6, sp);
      rd(5'h14, v); chk("R8 pop skips cut", v, 'h80);
      wr(5'h10, 2, sp);
      rd(5'h14, v); chk("R8 pop to idle", v, 'h100);

      // R10 idle end of interrupt
      lvl[3] = 1'b1;
      wr(5'h10, 3, sp);
      chk("R10 no set", sp, 0);
      rd(5'h14, v); chk("R10 rprio", v, 'h100);
      lvl[3] = 1'b0;

      // R11 re-pend of level interrupts
      lvl[4] = 1'b1; pend[4] = 1'b1; settle();
      ack(id, clr, all); chk("R11 claim id4", id, 4);
      wr(5'h10, 4, sp); chk("R11 level repend", sp, 'h10);
      edg[4] = 1'b1; pend[4] = 1'b1; settle();
      ack(id, clr, all);
      wr(5'h10, 4, sp); chk("R11 edge no repend", sp, 0);
      edg[4] = 1'b0; tgt[4] = 1'b0; pend[4] = 1'b1; settle();
      ack(id, clr, all);
      wr(5'h10, 4, sp); chk("R11 untargeted no repend", sp, 0);
      rd(5'h14, v); chk("R8 final idle", v, 'h100);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule